// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process ID, virtual page number) pair into a physical frame number by searching an inverted page table. The table has exactly one slot per physical frame, so the frame number is never stored: the slot index where the key is found is the frame. The table itself sits in an external synchronous RAM. The block issues one read per cycle and compares the returned entry against the request key.

The search starts at a slot chosen by a multiplicative hash of the key. If the slot holds a different key, the search moves to the next slot with wrap-around. It stops on a tag match (a hit), on a slot whose occupied bit is clear (a miss), or after it has visited every slot once (a miss). A hit returns the frame, the physical address formed from the frame and the untranslated page offset, and the entry's protection, dirty and used bits. Every result reports how many slots were read.

Top module: `ipt_lookup`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready_o` is 1 and `done_o`, `tbl_rd_o`, `hit_o` and `probes_o` are 0.
- R2: A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both 1. In that same cycle `tbl_rd_o` is 1 and `tbl_addr_o` equals bits [SLOT_W-1:0] of (vpn XOR (pid × HASH_MULT)).
- R3: A table entry is packed, from the MSB down, as {occupied, pid[PID_W], vpn[VPN_W], prot[PROT_W], dirty, used}, so `used` is bit 0 and `dirty` is bit 1. A slot is a hit only when its occupied bit is 1 and both its stored pid and vpn equal the request.
- R4: On a hit, `frame_o` equals the index of the matching slot, `paddr_o` equals {frame, offset}, and `prot_o`, `dirty_o` and `used_o` carry the entry's fields.
- R5: When an occupied slot does not match, the next read goes to (slot + 1) modulo 2^SLOT_W in the very next cycle, so slot 2^SLOT_W−1 is followed by slot 0.
- R6: A slot with its occupied bit clear ends the search as a miss, even if its stored tag equals the request. On any miss, `hit_o`, `frame_o`, `paddr_o`, `prot_o`, `dirty_o` and `used_o` are 0.
- R7: If every slot is occupied and none matches, the lookup ends as a miss with `probes_o` = 2^SLOT_W. A match in the last slot visited is still a hit.
- R8: `probes_o` equals the number of slots read. `done_o` rises exactly `probes_o` clock edges after the accepting edge.
- R9: While a lookup is in progress, `req_ready_o` is 0 and `req_valid_i` is ignored. No extra result is produced, and the running lookup's result is unchanged.
- R10: `done_o` is a one-cycle pulse. The result outputs hold their values until the next `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_pid_i | input | PID_W | Process ID of the request |
| req_vpn_i | input | VPN_W | Virtual page number of the request |
| req_off_i | input | OFF_W | Untranslated page offset |
| tbl_rd_o | output | 1 | Table RAM read enable |
| tbl_addr_o | output | SLOT_W | Table RAM read address (slot index) |
| tbl_entry_i | input | 1+PID_W+VPN_W+PROT_W+2 | Entry read back one cycle after the read |
| done_o | output | 1 | Result valid pulse |
| hit_o | output | 1 | Translation found |
| frame_o | output | SLOT_W | Frame number (slot index) on a hit |
| paddr_o | output | SLOT_W+OFF_W | Physical address on a hit |
| prot_o | output | PROT_W | Protection bits of the hit entry |
| dirty_o | output | 1 | Dirty bit of the hit entry |
| used_o | output | 1 | Used bit of the hit entry |
| probes_o | output | SLOT_W+1 | Number of slots read |

## Verification
The bench builds the block with its default parameters: 64 slots, 8-bit process IDs, 20-bit page numbers, 12-bit offsets and 3 protection bits. With only 64 slots, a search that visits every slot ends in 64 cycles, so a completely full table can be tested cheaply. The wrap from slot 63 to slot 0 is easy to reach by aiming a key at the top slot. Because the hash keeps only six bits, adding multiples of 64 to a page number gives keys that share a start slot, which makes collision chains of any length.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PROBE = 1'b1
  } probe_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int unsigned SLOT_W    = 6,
  parameter logic [31:0] HASH_MULT = 32'h9E37_79B1
) (
  input  logic [SLOT_W-1:0] pid_lo_i,
  input  logic [SLOT_W-1:0] vpn_lo_i,
  output logic [SLOT_W-1:0] slot_o
);
  // low product bits depend only on low operand bits
  localparam logic [SLOT_W-1:0] MULT_LO = HASH_MULT[SLOT_W-1:0];

  logic [SLOT_W-1:0] mix;

  always_comb begin
    mix    = pid_lo_i * MULT_LO;
    slot_o = vpn_lo_i ^ mix;
  end
endmodule

// File: rtl/ipt_tag_cmp.sv
module ipt_tag_cmp #(
  parameter int unsigned PID_W  = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PROT_W = 3
) (
  input  logic [1+PID_W+VPN_W+PROT_W+2-1:0] entry_i,
  input  logic [PID_W-1:0]                  key_pid_i,
  input  logic [VPN_W-1:0]                  key_vpn_i,
  output logic                              occupied_o,
  output logic                              match_o,
  output logic [PROT_W-1:0]                 prot_o,
  output logic                              dirty_o,
  output logic                              used_o
);
  localparam int unsigned ENT_W   = 1 + PID_W + VPN_W + PROT_W + 2;
  localparam int unsigned PROT_LO = 2;
  localparam int unsigned VPN_LO  = PROT_LO + PROT_W;
  localparam int unsigned PID_LO  = VPN_LO + VPN_W;

  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;

  always_comb begin
    occupied_o = entry_i[ENT_W-1];
    ent_pid    = entry_i[PID_LO +: PID_W];
    ent_vpn    = entry_i[VPN_LO +: VPN_W];
    prot_o     = entry_i[PROT_LO +: PROT_W];
    dirty_o    = entry_i[1];
    used_o     = entry_i[0];
    match_o    = occupied_o && (ent_pid == key_pid_i) && (ent_vpn == key_vpn_i);
  end
endmodule

// File: rtl/ipt_probe_ctrl.sv
module ipt_probe_ctrl
  import ipt_pkg::*;
#(
  parameter int unsigned PID_W  = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned SLOT_W = 6,
  parameter int unsigned PROT_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [PID_W-1:0]           req_pid_i,
  input  logic [VPN_W-1:0]           req_vpn_i,
  input  logic [OFF_W-1:0]           req_off_i,
  input  logic [SLOT_W-1:0]          start_slot_i,
  input  logic                       slot_occupied_i,
  input  logic                       slot_match_i,
  input  logic [PROT_W-1:0]          slot_prot_i,
  input  logic                       slot_dirty_i,
  input  logic                       slot_used_i,
  output logic [PID_W-1:0]           key_pid_o,
  output logic [VPN_W-1:0]           key_vpn_o,
  output logic                       rd_en_o,
  output logic [SLOT_W-1:0]          rd_addr_o,
  output logic                       done_o,
  output logic                       hit_o,
  output logic [SLOT_W-1:0]          frame_o,
  output logic [SLOT_W+OFF_W-1:0]    paddr_o,
  output logic [PROT_W-1:0]          prot_o,
  output logic                       dirty_o,
  output logic                       used_o,
  output logic [SLOT_W:0]            probes_o
);
  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned CNT_W = SLOT_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOTS);

  probe_st_e         st_q;
  logic [SLOT_W-1:0] cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFF_W-1:0]  off_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  vpn_q;

  logic              idle, probing, fire;
  logic              stop_hit, stop_empty, stop_full, finish;
  logic [SLOT_W-1:0] next_slot;

  always_comb begin
    idle       = (st_q == ST_IDLE);
    probing    = (st_q == ST_PROBE);
    fire       = idle && req_valid_i;
    stop_hit   = probing && slot_match_i;
    stop_empty = probing && !slot_occupied_i;
    stop_full  = probing && (cnt_q == CNT_FULL);
    finish     = stop_hit || stop_empty || stop_full;
    next_slot  = cur_q + 1'b1;
    // address is speculative; only the enable waits on the compare
    rd_en_o    = fire || (probing && !finish);
    rd_addr_o  = idle ? start_slot_i : next_slot;
  end

  assign req_ready_o = idle;
  assign key_pid_o   = pid_q;
  assign key_vpn_o   = vpn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      cnt_q <= '0;
      off_q <= '0;
      pid_q <= '0;
      vpn_q <= '0;
    end else if (fire) begin
      st_q  <= ST_PROBE;
      cur_q <= start_slot_i;
      cnt_q <= CNT_W'(1);
      off_q <= req_off_i;
      pid_q <= req_pid_i;
      vpn_q <= req_vpn_i;
    end else if (probing) begin
      if (finish) begin
        st_q <= ST_IDLE;
      end else begin
        cur_q <= next_slot;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      hit_o    <= 1'b0;
      frame_o  <= '0;
      paddr_o  <= '0;
      prot_o   <= '0;
      dirty_o  <= 1'b0;
      used_o   <= 1'b0;
      probes_o <= '0;
    end else begin
      done_o <= finish;
      if (finish) begin
        hit_o    <= stop_hit;
        probes_o <= cnt_q;
        if (stop_hit) begin
          frame_o <= cur_q;
          paddr_o <= {cur_q, off_q};
          prot_o  <= slot_prot_i;
          dirty_o <= slot_dirty_i;
          used_o  <= slot_used_i;
        end else begin
          frame_o <= '0;
          paddr_o <= '0;
          prot_o  <= '0;
          dirty_o <= 1'b0;
          used_o  <= 1'b0;
        end
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !finish |=> ($stable(hit_o) && $stable(frame_o) && $stable(probes_o) && $stable(paddr_o)));

  assert_probe_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (probes_o != '0) && (probes_o <= CNT_FULL));

  assert_miss_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (frame_o == '0) && (paddr_o == '0) && (prot_o == '0));
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int unsigned PID_W     = 8,
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned SLOT_W    = 6,
  parameter int unsigned PROT_W    = 3,
  parameter logic [31:0] HASH_MULT = 32'h9E37_79B1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  output logic                              req_ready_o,
  input  logic [PID_W-1:0]                  req_pid_i,
  input  logic [VPN_W-1:0]                  req_vpn_i,
  input  logic [OFF_W-1:0]                  req_off_i,
  output logic                              tbl_rd_o,
  output logic [SLOT_W-1:0]                 tbl_addr_o,
  input  logic [1+PID_W+VPN_W+PROT_W+2-1:0] tbl_entry_i,
  output logic                              done_o,
  output logic                              hit_o,
  output logic [SLOT_W-1:0]                 frame_o,
  output logic [SLOT_W+OFF_W-1:0]           paddr_o,
  output logic [PROT_W-1:0]                 prot_o,
  output logic                              dirty_o,
  output logic                              used_o,
  output logic [SLOT_W:0]                   probes_o
);
  localparam int unsigned ENT_W = 1 + PID_W + VPN_W + PROT_W + 2;
  localparam int unsigned SLOTS = 1 << SLOT_W;

  logic [SLOT_W-1:0] start_slot;
  logic [PID_W-1:0]  key_pid;
  logic [VPN_W-1:0]  key_vpn;
  logic              slot_occupied, slot_match, slot_dirty, slot_used;
  logic [PROT_W-1:0] slot_prot;

  ipt_hash #(
    .SLOT_W    (SLOT_W),
    .HASH_MULT (HASH_MULT)
  ) u_hash (
    .pid_lo_i (req_pid_i[SLOT_W-1:0]),
    .vpn_lo_i (req_vpn_i[SLOT_W-1:0]),
    .slot_o   (start_slot)
  );

  ipt_tag_cmp #(
    .PID_W  (PID_W),
    .VPN_W  (VPN_W),
    .PROT_W (PROT_W)
  ) u_cmp (
    .entry_i    (tbl_entry_i),
    .key_pid_i  (key_pid),
    .key_vpn_i  (key_vpn),
    .occupied_o (slot_occupied),
    .match_o    (slot_match),
    .prot_o     (slot_prot),
    .dirty_o    (slot_dirty),
    .used_o     (slot_used)
  );

  ipt_probe_ctrl #(
    .PID_W  (PID_W),
    .VPN_W  (VPN_W),
    .OFF_W  (OFF_W),
    .SLOT_W (SLOT_W),
    .PROT_W (PROT_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_pid_i       (req_pid_i),
    .req_vpn_i       (req_vpn_i),
    .req_off_i       (req_off_i),
    .start_slot_i    (start_slot),
    .slot_occupied_i (slot_occupied),
    .slot_match_i    (slot_match),
    .slot_prot_i     (slot_prot),
    .slot_dirty_i    (slot_dirty),
    .slot_used_i     (slot_used),
    .key_pid_o       (key_pid),
    .key_vpn_o       (key_vpn),
    .rd_en_o         (tbl_rd_o),
    .rd_addr_o       (tbl_addr_o),
    .done_o          (done_o),
    .hit_o           (hit_o),
    .frame_o         (frame_o),
    .paddr_o         (paddr_o),
    .prot_o          (prot_o),
    .dirty_o         (dirty_o),
    .used_o          (used_o),
    .probes_o        (probes_o)
  );

  // last slot address sent to the RAM, for the checks below
  logic [SLOT_W-1:0] last_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_rd_q <= '0;
    else if (tbl_rd_o) last_rd_q <= tbl_addr_o;
  end

  assert_linear_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_rd_o && !req_ready_o) |-> (tbl_addr_o == SLOT_W'(last_rd_q + 1'b1)));

  assert_hit_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> (frame_o == last_rd_q));

  assert_hit_occupied_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> $past(tbl_entry_i[ENT_W-1]));

  assert_miss_on_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o && (probes_o != (SLOT_W+1)'(SLOTS))) |-> !$past(tbl_entry_i[ENT_W-1]));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |-> !tbl_rd_o);
endmodule

// File: tb/ipt_lookup_test.sv
`timescale 1ns/1ps
module ipt_lookup_test;
  localparam int unsigned PID_W  = 8;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned SLOT_W = 6;
  localparam int unsigned PROT_W = 3;
  localparam logic [31:0] MULT   = 32'h9E37_79B1;
  localparam int unsigned SLOTS  = 1 << SLOT_W;
  localparam int unsigned ENT_W  = 1 + PID_W + VPN_W + PROT_W + 2;
  localparam int unsigned PA_W   = SLOT_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [PID_W-1:0]   req_pid = '0;
  logic [VPN_W-1:0]   req_vpn = '0;
  logic [OFF_W-1:0]   req_off = '0;
  logic               tbl_rd;
  logic [SLOT_W-1:0]  tbl_addr;
  logic [ENT_W-1:0]   tbl_entry;
  logic               done, hit, dirty, used;
  logic [SLOT_W-1:0]  frame;
  logic [PA_W-1:0]    paddr;
  logic [PROT_W-1:0]  prot;
  logic [SLOT_W:0]    probes;

  ipt_lookup #(
    .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
    .SLOT_W(SLOT_W), .PROT_W(PROT_W), .HASH_MULT(MULT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pid_i(req_pid), .req_vpn_i(req_vpn), .req_off_i(req_off),
    .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_entry_i(tbl_entry),
    .done_o(done), .hit_o(hit), .frame_o(frame), .paddr_o(paddr),
    .prot_o(prot), .dirty_o(dirty), .used_o(used), .probes_o(probes)
  );

  // table RAM model, one-cycle synchronous read
  logic [ENT_W-1:0] mem [SLOTS];
  always_ff @(posedge clk) if (tbl_rd) tbl_entry <= mem[tbl_addr];

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] frame;
    logic [PA_W-1:0]   paddr;
    logic [PROT_W-1:0] prot;
    logic              dirty;
    logic              used;
    logic [SLOT_W:0]   probes;
    logic [31:0]       due;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic [SLOT_W-1:0] slot_of(input logic [PID_W-1:0] pid, input logic [VPN_W-1:0] vpn);
    logic [31:0] m;
    m = 32'(pid) * MULT;
    return SLOT_W'(32'(vpn) ^ m);
  endfunction

  // R3 layout: {occupied, pid, vpn, prot, dirty, used}
  function automatic logic [ENT_W-1:0] mk(input logic v, input logic [PID_W-1:0] pid,
      input logic [VPN_W-1:0] vpn, input logic [PROT_W-1:0] pr, input logic d, input logic u);
    return {v, pid, vpn, pr, d, u};
  endfunction

  function automatic exp_t model(input logic [PID_W-1:0] pid, input logic [VPN_W-1:0] vpn,
      input logic [OFF_W-1:0] off);
    exp_t e;
    logic [SLOT_W-1:0] s;
    logic [ENT_W-1:0] w;
    e = '0;
    s = slot_of(pid, vpn);
    for (int i = 0; i < SLOTS; i++) begin
      w = mem[s];
      if (w[ENT_W-1] && w[ENT_W-2 -: PID_W] == pid && w[VPN_W+PROT_W+1 -: VPN_W] == vpn) begin
        e.hit = 1'b1; e.frame = s; e.paddr = {s, off};
        e.prot = w[PROT_W+1:2]; e.dirty = w[1]; e.used = w[0];
        e.probes = (SLOT_W+1)'(i + 1);
        return e;
      end
      if (!w[ENT_W-1]) begin
        e.probes = (SLOT_W+1)'(i + 1);
        return e;
      end
      s = s + 1'b1;
    end
    e.probes = (SLOT_W+1)'(SLOTS);
    return e;
  endfunction

  task automatic lookup(input logic [PID_W-1:0] pid, input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e = model(pid, vpn, off);
    e.due = cyc + 1 + 32'(e.probes);
    sb_q.push_back(e);
    req_valid = 1'b1; req_pid = pid; req_vpn = vpn; req_off = off;
    #1;
    chk(tbl_rd == 1'b1, "R2 read on accept", 64'(tbl_rd), 64'd1);
    chk(tbl_addr == slot_of(pid, vpn), "R2 start slot", 64'(tbl_addr), 64'(slot_of(pid, vpn)));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < SLOTS; i++) mem[i] = '0;
  endtask

  // scoreboard monitor
  logic prev_done = 1'b0;
  logic hold_pending = 1'b0;
  exp_t last_e;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done == 1'b0, "R10 done pulse width", 64'(done), 64'd0);
      if (hold_pending && !done) begin
        chk(hit == last_e.hit && probes == last_e.probes && frame == last_e.frame,
            "R10 result held", 64'({hit, frame, probes}), 64'({last_e.hit, last_e.frame, last_e.probes}));
        hold_pending = 1'b0;
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", 64'(done), 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(hit == e.hit, "R3 hit flag", 64'(hit), 64'(e.hit));
          chk(frame == e.frame, "R4 frame", 64'(frame), 64'(e.frame));
          chk(paddr == e.paddr, "R4 paddr", 64'(paddr), 64'(e.paddr));
          chk({prot, dirty, used} == {e.prot, e.dirty, e.used}, "R4 prot/dirty/used",
              64'({prot, dirty, used}), 64'({e.prot, e.dirty, e.used}));
          chk(probes == e.probes, "R8 probe count", 64'(probes), 64'(e.probes));
          chk(cyc == e.due, "R8 result latency", 64'(cyc), 64'(e.due));
          last_e = e;
          hold_pending = 1'b1;
        end
      end
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual_cycles=%0d expected<%0d", cyc, 100000);
    finish_run();
  end

  initial begin
    logic [PID_W-1:0] p, q;
    logic [VPN_W-1:0] v0, w;
    logic [SLOT_W-1:0] h0, hg;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0 && tbl_rd == 1'b0, "R1 done/rd in reset", 64'({done, tbl_rd}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit == 1'b0 && probes == '0, "R1 outputs after reset", 64'({hit, probes}), 64'd0);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 idle after reset", 64'({req_ready, done}), 64'h2);

    // R6 empty table
    lookup(8'h03, 20'h12345, 12'hABC);
    settle();

    // R2/R4 direct hit, then R5 collision chain
    p  = 8'h5A;
    v0 = 20'h0ABC0;
    h0 = slot_of(p, v0);
    mem[h0]              = mk(1'b1, p, v0,          3'b101, 1'b1, 1'b0);
    mem[SLOT_W'(h0 + 1)] = mk(1'b1, p, v0 + 20'd64,  3'b010, 1'b0, 1'b1);
    mem[SLOT_W'(h0 + 2)] = mk(1'b1, p, v0 + 20'd128, 3'b111, 1'b1, 1'b1);
    lookup(p, v0, 12'h123);
    lookup(p, v0 + 20'd128, 12'hFFF);
    lookup(p, v0 + 20'd64, 12'h001);
    lookup(p, v0 + 20'd192, 12'h055);   // R6 miss after 4 probes
    settle();

    // R6 unoccupied slot whose stale tag matches
    mem[SLOT_W'(h0 + 3)] = mk(1'b0, p, v0 + 20'd192, 3'b111, 1'b1, 1'b1);
    lookup(p, v0 + 20'd192, 12'h055);
    settle();

    // R5 wrap from the top slot to slot 0
    clear_mem();
    q = 8'h11;
    w = {14'h2A5, SLOT_W'(6'd63 ^ SLOT_W'(32'(q) * MULT))};
    mem[SLOTS-1] = mk(1'b1, q, w,         3'b001, 1'b0, 1'b0);
    mem[0]       = mk(1'b1, q, w + 20'd64, 3'b100, 1'b0, 1'b1);
    lookup(q, w + 20'd64, 12'h7E7);
    settle();

    // R7 full table, no match; R9 requests ignored while busy
    for (int i = 0; i < SLOTS; i++) mem[i] = mk(1'b1, 8'hFF, 20'(i), 3'(i), 1'b0, 1'b1);
    lookup(8'h01, 20'h00777, 12'h321);
    req_valid = 1'b1; req_pid = 8'h5A; req_vpn = v0; req_off = 12'h444;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    settle();

    // R7 match in the last slot visited
    hg = slot_of(8'h02, 20'h31337);
    mem[SLOT_W'(hg - 1)] = mk(1'b1, 8'h02, 20'h31337, 3'b110, 1'b1, 1'b0);
    lookup(8'h02, 20'h31337, 12'hBEE);
    // back-to-back requests, R8 latency
    lookup(8'h02, 20'h31337, 12'h0F0);
    lookup(8'h09, 20'h00001, 12'h00F);
    settle();

    finish_run();
  end
endmodule